// File: doc/BRIEF.md
# Sign-Aware Multiply-Accumulator

This block multiplies two 18-bit operands and folds each product into a wide running total. Each operand can be declared signed or unsigned, cycle by cycle. The product is signed whenever either operand is signed, and that choice also sets how the running total is read: as two's complement or as a plain binary number. A direction input picks, per term, whether the product is added to the total or taken away from it.

A load input starts a new total from the current term, without an idle cycle. The loaded value is the product itself when adding and its negation when subtracting. An overflow output pulses for exactly one cycle when a term carries the total outside its representable range. In unsigned mode this includes a total that would drop below zero. Keeping a sticky record of the pulse is left to the logic around the block.

An optional register stage can sit after the multiplier. Each control input has its own delay parameter (0, 1 or 2 stages), so the controls can line up with the product they act on. With the defaults (multiplier register on, sign delay 0, direction and load delays 1), the operands and all controls of one term are presented in the same cycle. The total for that term appears two clock edges later.

Top module: `sign_mac`

## Requirements
- R1: With both sign inputs low, a term is the unsigned product of the two operands.
- R2: A high `a_signed` (`b_signed`) makes the operand a two's complement value. The product is signed, and the total is read as signed, when either sign input is high.
- R3: With `add_sub` high and `sync_load` low, the product is added to the stored total. A zero product leaves the total unchanged and raises no overflow.
- R4: With `add_sub` low and `sync_load` low, the product is subtracted from the stored total.
- R5: With `sync_load` high, the total becomes the product (`add_sub` high) or the negated product (`add_sub` low). Overflow stays low for that term, and the next term accumulates on the following cycle.
- R6: In signed mode, `overflow` goes high for a term whose true sum lies outside the signed `ACC_W`-bit range. The total keeps the wrapped low `ACC_W` bits.
- R7: In unsigned mode, `overflow` goes high for a term whose true sum exceeds 2^`ACC_W`-1 or falls below zero. The total keeps the wrapped low `ACC_W` bits.
- R8: `overflow` is high only for the term that overflowed. It returns low on the next term that stays in range.
- R9: With the default delays, operands and controls presented before clock edge k give their total on `result` after edge k+1.
- R10: While `ce` is low, no register changes: `result`, `overflow` and the pending term are held.
- R11: A high `clr` at a clock edge zeroes the total, the overflow flag, the product register and the control delay registers, whatever the value of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear |
| ce | input | 1 | Clock enable for every register |
| op_a | input | A_W | First operand |
| op_b | input | B_W | Second operand |
| a_signed | input | 1 | First operand is two's complement |
| b_signed | input | 1 | Second operand is two's complement |
| add_sub | input | 1 | 1 = add product, 0 = subtract product |
| sync_load | input | 1 | Start a new total from this term |
| result | output | ACC_W | Running total |
| overflow | output | 1 | One-cycle overflow/underflow pulse |

## Verification
The bench builds the block with `ACC_W` = 40 and keeps the default delays and the multiplier register. With a 40-bit total, a few dozen full-scale terms are enough to reach signed overflow, signed underflow to exactly the most negative value, and unsigned overflow. At the full 52 bits this would take up to 2^17 terms. The 18-bit operand width is unchanged, so the corner products (the most negative value squared, all-ones times minus one) are exercised as they would be in the full-width build. The same-cycle control timing from R9 is checked on every term.

// File: rtl/sign_mac_pkg.sv
package sign_mac_pkg;

  // Controls that travel alongside a product to the accumulator stage
  typedef struct packed {
    logic add;
    logic load;
  } acc_ctrl_t;

  // Width of the full-precision signed product of two operands
  function automatic int prod_width(input int aw, input int bw);
    return aw + bw + 2;
  endfunction

endpackage

// File: rtl/sign_mac_dly.sv
module sign_mac_dly #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [D];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < D; i++) stg[i] <= '0;
    end else if (ce) begin
      stg[0] <= d;
      for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[D-1];

endmodule

// File: rtl/sign_mac_mul.sv
module sign_mac_mul #(
  parameter int A_W  = 18,
  parameter int B_W  = 18,
  parameter int PIPE = 1,
  localparam int PW  = sign_mac_pkg::prod_width(A_W, B_W)
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 ce,
  input  logic [A_W-1:0]       a,
  input  logic [B_W-1:0]       b,
  input  logic                 a_sgn,
  input  logic                 b_sgn,
  output logic signed [PW-1:0] prod,
  output logic                 prod_sgn
);

  logic signed [A_W:0]  ax;
  logic signed [B_W:0]  bx;
  logic signed [PW-1:0] pr;

  // One extra top bit per operand carries its sign or a zero
  assign ax = {a_sgn & a[A_W-1], a};
  assign bx = {b_sgn & b[B_W-1], b};
  assign pr = PW'(ax) * PW'(bx);

  generate
    if (PIPE != 0) begin : g_reg
      logic signed [PW-1:0] pr_q;
      logic                 sg_q;
      always_ff @(posedge clk) begin
        if (clr) begin
          pr_q <= '0;
          sg_q <= 1'b0;
        end else if (ce) begin
          pr_q <= pr;
          sg_q <= a_sgn | b_sgn;
        end
      end
      assign prod     = pr_q;
      assign prod_sgn = sg_q;
    end else begin : g_comb
      assign prod     = pr;
      assign prod_sgn = a_sgn | b_sgn;
    end
  endgenerate

endmodule

// File: rtl/sign_mac_acc.sv
module sign_mac_acc #(
  parameter int PW    = 38,
  parameter int ACC_W = 52,
  localparam int W    = ACC_W + 2
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 ce,
  input  logic signed [PW-1:0] prod,
  input  logic                 sgn,
  input  sign_mac_pkg::acc_ctrl_t ctl,
  output logic [ACC_W-1:0]     acc,
  output logic                 ovf
);

  logic signed [W-1:0] base, pext, full, seed;
  logic                out_of_range;
  logic [ACC_W-1:0]    acc_d;

  // The stored total is read as signed or unsigned, two guard bits on top
  assign base = {{2{sgn & acc[ACC_W-1]}}, acc};
  assign pext = W'(prod);
  assign full = ctl.add ? (base + pext) : (base - pext);
  assign seed = ctl.add ? pext : -pext;

  always_comb begin
    if (sgn) out_of_range = (|full[W-1:ACC_W-1]) && !(&full[W-1:ACC_W-1]);
    else     out_of_range = |full[W-1:ACC_W];
  end

  assign acc_d = ctl.load ? seed[ACC_W-1:0] : full[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (clr) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (ce) begin
      acc <= acc_d;
      ovf <= out_of_range & ~ctl.load;
    end
  end

  // R10: nothing moves while the enable is low
  a_r10_hold: assert property (@(posedge clk) disable iff (clr)
    !ce |=> $stable(acc) && $stable(ovf));

  // R5: a loaded term never reports overflow
  a_r5_load_no_ovf: assert property (@(posedge clk) disable iff (clr)
    (ce && ctl.load) |=> !ovf);

  // R3: accumulating a zero product keeps the total and the flag low
  a_r3_zero_term: assert property (@(posedge clk) disable iff (clr)
    (ce && !ctl.load && prod == '0) |=> (acc == $past(acc)) && !ovf);

endmodule

// File: rtl/sign_mac.sv
module sign_mac #(
  parameter int A_W       = 18,
  parameter int B_W       = 18,
  parameter int ACC_W     = 52,
  parameter int PIPE      = 1,
  parameter int SIGN_DLY  = 0,
  parameter int DIR_DLY   = 1,
  parameter int LOAD_DLY  = 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ce,
  input  logic [A_W-1:0]   op_a,
  input  logic [B_W-1:0]   op_b,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             add_sub,
  input  logic             sync_load,
  output logic [ACC_W-1:0] result,
  output logic             overflow
);

  import sign_mac_pkg::*;

  localparam int PW = prod_width(A_W, B_W);

  logic [1:0]           sgn_d;
  logic                 add_d, load_d;
  logic signed [PW-1:0] prod;
  logic                 prod_sgn;
  acc_ctrl_t            ctl;

  // Sign controls act at the multiplier; their delay is chosen per build
  generate
    if (SIGN_DLY == 0) begin : g_sgn_thru
      assign sgn_d = {a_signed, b_signed};
    end else begin : g_sgn_dly
      sign_mac_dly #(.W(2), .D(SIGN_DLY)) u_sgn (
        .clk(clk), .clr(clr), .ce(ce), .d({a_signed, b_signed}), .q(sgn_d));
    end

    if (DIR_DLY == 0) begin : g_dir_thru
      assign add_d = add_sub;
    end else begin : g_dir_dly
      sign_mac_dly #(.W(1), .D(DIR_DLY)) u_dir (
        .clk(clk), .clr(clr), .ce(ce), .d(add_sub), .q(add_d));
    end

    if (LOAD_DLY == 0) begin : g_ld_thru
      assign load_d = sync_load;
    end else begin : g_ld_dly
      sign_mac_dly #(.W(1), .D(LOAD_DLY)) u_ld (
        .clk(clk), .clr(clr), .ce(ce), .d(sync_load), .q(load_d));
    end
  endgenerate

  assign ctl.add  = add_d;
  assign ctl.load = load_d;

  sign_mac_mul #(.A_W(A_W), .B_W(B_W), .PIPE(PIPE)) u_mul (
    .clk(clk), .clr(clr), .ce(ce),
    .a(op_a), .b(op_b), .a_sgn(sgn_d[1]), .b_sgn(sgn_d[0]),
    .prod(prod), .prod_sgn(prod_sgn));

  sign_mac_acc #(.PW(PW), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .clr(clr), .ce(ce),
    .prod(prod), .sgn(prod_sgn), .ctl(ctl),
    .acc(result), .ovf(overflow));

  // R11: a clear leaves a zero total and a low flag at the port
  a_r11_clear: assert property (@(posedge clk)
    clr |=> (result == '0) && !overflow);

endmodule

// File: tb/sign_mac_tb.sv
module sign_mac_tb;

  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          ce = 1'b1;
  logic [17:0]   op_a = '0, op_b = '0;
  logic          a_signed = 1'b0, b_signed = 1'b0, add_sub = 1'b1, sync_load = 1'b0;
  logic [AW-1:0] result;
  logic          overflow;

  always #4 clk = ~clk;  // 125 MHz

  sign_mac #(.ACC_W(AW)) u_dut (
    .clk(clk), .clr(clr), .ce(ce), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .add_sub(add_sub),
    .sync_load(sync_load), .result(result), .overflow(overflow));

  typedef struct {
    longint        due;
    logic [AW-1:0] res;
    bit            ovf;
    string         tag;
  } exp_t;

  exp_t   q[$];
  exp_t   e;
  longint cyc = 0;
  int     n_chk = 0, n_bad = 0;
  longint m_raw = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each expected item in the cycle its total appears
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      n_chk++;
      if (result !== e.res || overflow !== e.ovf) begin
        n_bad++;
        $display("FAIL %s: result=%h overflow=%b expected result=%h overflow=%b",
                 e.tag, result, overflow, e.res, e.ovf);
      end
    end
  end

  // Driver: apply one term and push the value the requirements predict
  task automatic drive(input logic [17:0] a, input logic [17:0] b,
                       input bit sa, input bit sb, input bit ad, input bit ld,
                       input string tag);
    longint av, bv, p, base, full;
    bit sg, ov;
    @(negedge clk);
    op_a = a; op_b = b; a_signed = sa; b_signed = sb;
    add_sub = ad; sync_load = ld; ce = 1'b1;
    sg = sa | sb;
    av = sa ? longint'($signed(a)) : longint'(a);
    bv = sb ? longint'($signed(b)) : longint'(b);
    p  = av * bv;
    if (ld) begin
      full = ad ? p : -p;
      ov = 1'b0;
    end else begin
      base = (sg && m_raw[AW-1]) ? m_raw - (longint'(1) << AW) : m_raw;
      full = ad ? base + p : base - p;
      if (sg) ov = (full > (longint'(1) << (AW-1)) - 1) || (full < -(longint'(1) << (AW-1)));
      else    ov = (full > (longint'(1) << AW) - 1) || (full < 0);
    end
    m_raw = full & ((longint'(1) << AW) - 1);
    q.push_back(exp_t'{cyc + 2, m_raw[AW-1:0], ov, tag});
  endtask

  task automatic idle(input string tag);
    drive(18'd0, 18'd0, 1'b0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  // Enable low with junk inputs: every register must hold
  task automatic frozen(input string tag);
    @(negedge clk);
    ce = 1'b0; op_a = 18'h2AAAA; op_b = 18'h15555;
    a_signed = 1'b1; b_signed = 1'b0; add_sub = 1'b0; sync_load = 1'b1;
    q.push_back(exp_t'{cyc + 2, m_raw[AW-1:0], 1'b0, tag});
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      @(negedge clk);
      op_a = '0; op_b = '0; a_signed = 1'b0; b_signed = 1'b0;
      add_sub = 1'b1; sync_load = 1'b0; ce = 1'b1;
    end
  endtask

  task automatic direct_zero(input string tag);
    n_chk++;
    if (result !== '0 || overflow !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: result=%h overflow=%b expected result=0 overflow=0",
               tag, result, overflow);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct_zero("R11 reset state");
    clr = 1'b0;

    // R1 / R9: unsigned products, same-cycle controls, two-edge latency
    drive(18'd1000, 18'd3000, 0, 0, 1, 1, "R1/R9 unsigned load");
    drive(18'd2, 18'd5, 0, 0, 1, 0, "R1 unsigned add");
    drive(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 1, "R1 max unsigned product");

    // R2: sign control per operand
    drive(18'h3FFFB, 18'd7, 1, 0, 1, 1, "R2 signed a times unsigned b");
    drive(18'h3FFFD, 18'h3FFFC, 1, 1, 1, 1, "R2 both signed");
    drive(18'h3FFFF, 18'h3FFFF, 0, 1, 1, 1, "R2 unsigned a times signed b");
    drive(18'h20000, 18'h20000, 1, 1, 1, 1, "R2 most negative squared");

    // R3 / R4: direction per term
    drive(18'd100, 18'd1, 0, 0, 1, 1, "R5 load before add/sub");
    drive(18'd30, 18'd2, 0, 0, 0, 0, "R4 subtract");
    drive(18'd7, 18'd7, 0, 0, 1, 0, "R3 add");
    drive(18'h3FFF9, 18'd4, 1, 0, 0, 0, "R4 subtract negative product");
    idle("R3 zero product");

    // R5: loads back to back, negated seed when subtracting
    drive(18'd6, 18'd6, 0, 0, 0, 1, "R5 negated load unsigned");
    drive(18'd9, 18'd9, 1, 1, 0, 1, "R5 negated load signed");
    drive(18'd11, 18'd3, 0, 0, 1, 1, "R5 load on next cycle");
    drive(18'd4, 18'd4, 0, 0, 1, 0, "R5 no idle cycle after load");

    // R7 / R8: unsigned underflow then recovery
    drive(18'd5, 18'd1, 0, 0, 1, 1, "R5 seed for underflow");
    drive(18'd10, 18'd1, 0, 0, 0, 0, "R7 unsigned underflow");
    idle("R8 flag drops");

    // R6 / R8: signed overflow after 32 terms of 2^34
    drive(18'h20000, 18'h20000, 1, 1, 1, 1, "R6 seed");
    for (int i = 0; i < 31; i++) drive(18'h20000, 18'h20000, 1, 1, 1, 0, "R6 signed overflow");
    drive(18'h20000, 18'h20000, 1, 1, 1, 0, "R8 flag low after wrap");

    // R6: down to the most negative value exactly, then underflow
    drive(18'h20000, 18'h20000, 1, 1, 0, 1, "R6 negative seed");
    for (int i = 0; i < 31; i++) drive(18'h20000, 18'h20000, 1, 1, 0, 0, "R6 reach minimum");
    drive(18'd1, 18'd1, 1, 1, 0, 0, "R6 signed underflow");
    idle("R8 flag drops after underflow");

    // R7: unsigned overflow on the 17th near-full-scale product
    drive(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 1, "R7 seed");
    for (int i = 0; i < 16; i++) drive(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0, "R7 unsigned overflow");
    idle("R8 flag drops after unsigned overflow");

    // R10: enable low holds everything, including the pending term
    drive(18'd12, 18'd12, 0, 0, 1, 1, "R10 value to hold");
    idle("R10 pre-idle");
    idle("R10 pre-idle");
    for (int i = 0; i < 3; i++) frozen("R10 enable low hold");
    idle("R10 resume");
    idle("R10 resume");
    drive(18'd1, 18'd1, 0, 0, 1, 0, "R10 accumulates after resume");
    idle("R10 tail");

    // R11: clear in the middle of a run, with enable low
    drain();
    @(negedge clk);
    clr = 1'b1; ce = 1'b0;
    @(negedge clk);
    @(negedge clk);
    direct_zero("R11 clear mid-run");
    clr = 1'b0; ce = 1'b1;
    m_raw = 0;
    drive(18'd3, 18'd3, 0, 0, 1, 0, "R11 accumulate from zero after clear");
    idle("R11 tail");

    drain();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule